// File: doc/BRIEF.md
# Register-Indirect Jump-and-Link Unit

This block executes the RV32I register-indirect jump-and-link instruction within a simple in-order core. In each cycle it receives one instruction word together with its PC and the operand already read from the source register. The target address is the source value plus a sign-extended immediate, with bit 0 forced low. The return address, PC+4, is sent to the register-file write port. The target and the write enable leave the block in the same cycle, with no register in the path.

The block also classifies how the instruction uses the two link registers, x1 and x5. From this it raises exactly one of three return-address-stack actions: push, pop, or pop-then-push. The same actions update an internal eight-entry return-address stack at the clock edge. The top of that stack is offered to fetch as the predicted return target.

Because compressed instructions are not supported, a target whose bit 1 is set raises a misalignment exception. In that case the instruction has no other effect.

Top module: `jalr_unit`

## Requirements
- R1: The instruction is recognised only when instValid is high, bits 6:0 of instWord equal 7'b1100111 and bits 14:12 equal 3'b000. For any other word, redirectValid, rfWrEn, misalignExc and all three stack hints are low.
- R2: redirectTarget equals rs1Val plus the sign extension of instWord[31:20], taken modulo 2^32, with bit 0 cleared. The addition wraps around.
- R3: Whenever redirectValid is high, bit 0 of redirectTarget is zero, even when the sum is odd.
- R4: For a recognised, aligned instruction, rfWrAddr equals instWord[11:7] and rfWrData equals pcIn+4. rfWrEn is high unless rd is x0.
- R5: When rd (instWord[11:7]) is zero, rfWrEn stays low while the redirect still happens.
- R6: When bit 1 of the cleared target is set, misalignExc is high and redirectValid, rfWrEn and all stack hints are low. The stack is left unchanged.
- R7: Register 1 and register 5 count as link registers. The hints are set as follows:
  - rasPush when rd is a link register and rs1 is not, or when rd and rs1 are the same link register.
  - rasPop when rs1 is a link register and rd is not.
  - rasPopPush when rd and rs1 are two different link registers.
  - None when neither is a link register.
  - At most one hint is high at any time.
- R8: The return form (rd=x0, rs1=x1, immediate 0) raises rasPop and does not write the register file.
- R9: After a push, predTarget equals the pushed PC+4 and predValid is high from the next cycle.
- R10: A pop exposes the previous entry. A pop on an empty stack changes nothing. While the stack is empty, predTarget is 0 and predValid is low.
- R11: The stack holds 8 entries. A push into a full stack overwrites the oldest entry, so after nine pushes, eight pops return the eight newest values in reverse order.
- R12: A pop-then-push replaces the top entry with PC+4 and keeps the depth the same. On an empty stack it acts as a push.
- R13: A synchronous active-high rst empties the stack, so predValid is low in the cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the stack |
| instValid | input | 1 | Instruction word is valid this cycle |
| instWord | input | 32 | Instruction word |
| pcIn | input | 32 | PC of the instruction |
| rs1Val | input | 32 | Source register value read before any write by this instruction |
| redirectValid | output | 1 | Take the jump |
| redirectTarget | output | 32 | Jump target with bit 0 cleared |
| rfWrEn | output | 1 | Register-file write enable for the link value |
| rfWrAddr | output | 5 | Destination register index |
| rfWrData | output | 32 | Link value, PC+4 |
| misalignExc | output | 1 | Target not 4-byte aligned |
| rasPush | output | 1 | Stack hint: push |
| rasPop | output | 1 | Stack hint: pop |
| rasPopPush | output | 1 | Stack hint: pop then push |
| predTarget | output | 32 | Top of the return-address stack, 0 if empty |
| predValid | output | 1 | Stack is not empty |

## Verification
The hardest state to reach from the ports is a full stack that has wrapped. There, an overwrite of the oldest entry is visible only after a long chain of pops that must all be aligned returns. Directed sequences push nine times and then pop past empty, and the underflow shows up as a zeroed prediction. Seeded random stimulus draws rd and rs1 mostly from x0, x1, x5 and one other register, and it randomises the low two bits of rs1Val. This mixes all hint classes, misalignment and the same-register case, and a queue model in the bench tracks the expected stack content.

// File: rtl/jalr_pkg.sv
package jalr_pkg;

  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [2:0] F3_JALR   = 3'b000;
  localparam logic [4:0] LINK_REGA = 5'd1;
  localparam logic [4:0] LINK_REGB = 5'd5;
  localparam int         IMM_W     = 12;
  localparam int         REG_IDX_W = 5;

  typedef struct packed {
    logic hit;       // instruction recognised
    logic redirect;  // take the jump
    logic linkWr;    // write PC+4 into rd
    logic misalign;  // target bit 1 set
    logic push;
    logic pop;
    logic popPush;
    logic isReturn;  // rd=x0, rs1=x1, imm=0
  } ctrlStrobe_t;

endpackage

// File: rtl/jalr_datapath.sv
module jalr_datapath
  import jalr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]          instWord,
  input  logic [XLEN-1:0]      pcIn,
  input  logic [XLEN-1:0]      rs1Val,
  output logic [6:0]           opcode,
  output logic [2:0]           funct3,
  output logic [REG_IDX_W-1:0] rdIdx,
  output logic [REG_IDX_W-1:0] rs1Idx,
  output logic                 immZero,
  output logic                 targetBit1,
  output logic [XLEN-1:0]      target,
  output logic [XLEN-1:0]      linkVal
);

  localparam int SEXT_W = XLEN - IMM_W;

  logic [IMM_W-1:0] immRaw;
  logic [XLEN-1:0]  immExt;
  logic [XLEN-1:0]  sum;

  // I-type field extraction
  assign opcode = instWord[6:0];
  assign rdIdx  = instWord[11:7];
  assign funct3 = instWord[14:12];
  assign rs1Idx = instWord[19:15];
  assign immRaw = instWord[31:20];

  assign immExt  = {{SEXT_W{immRaw[IMM_W-1]}}, immRaw};
  assign immZero = (immRaw == '0);

  // Wraparound add, then force the low bit to zero
  assign sum        = rs1Val + immExt;
  assign target     = sum & ~XLEN'(1);
  assign targetBit1 = target[1];

  assign linkVal = pcIn + XLEN'(4);

endmodule

// File: rtl/jalr_ctrl.sv
module jalr_ctrl
  import jalr_pkg::*;
(
  input  logic                 instValid,
  input  logic [6:0]           opcode,
  input  logic [2:0]           funct3,
  input  logic [REG_IDX_W-1:0] rdIdx,
  input  logic [REG_IDX_W-1:0] rs1Idx,
  input  logic                 immZero,
  input  logic                 targetBit1,
  output ctrlStrobe_t          strobe
);

  logic hit, mis, ok;
  logic rdIsLink, rs1IsLink, sameReg;

  assign hit = instValid && (opcode == OPC_JALR) && (funct3 == F3_JALR);
  assign mis = hit && targetBit1;
  assign ok  = hit && !mis;

  assign rdIsLink  = (rdIdx == LINK_REGA) || (rdIdx == LINK_REGB);
  assign rs1IsLink = (rs1Idx == LINK_REGA) || (rs1Idx == LINK_REGB);
  assign sameReg   = (rdIdx == rs1Idx);

  always_comb begin
    strobe          = '0;
    strobe.hit      = hit;
    strobe.misalign = mis;
    strobe.redirect = ok;
    strobe.linkWr   = ok && (rdIdx != '0);
    strobe.push     = ok && rdIsLink && (!rs1IsLink || sameReg);
    strobe.pop      = ok && rs1IsLink && !rdIsLink;
    strobe.popPush  = ok && rdIsLink && rs1IsLink && !sameReg;
    strobe.isReturn = ok && (rdIdx == '0) && (rs1Idx == LINK_REGA) && immZero;
  end

endmodule

// File: rtl/jalr_ras.sv
module jalr_ras #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  logic            popPush,
  input  logic [XLEN-1:0] pushVal,
  output logic [XLEN-1:0] predTarget,
  output logic            predValid
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [XLEN-1:0]  entry [DEPTH];
  logic [PTR_W-1:0] topPtr, nextPtr, prevPtr, wrPtr;
  logic [CNT_W-1:0] cnt;
  logic             empty, doWrite, doAdvance, doRetreat;

  assign empty   = (cnt == '0);
  assign nextPtr = (topPtr == PTR_LAST) ? '0 : topPtr + PTR_W'(1);
  assign prevPtr = (topPtr == '0) ? PTR_LAST : topPtr - PTR_W'(1);

  // A swap on an empty stack degrades to a push
  assign doAdvance = push || (popPush && empty);
  assign doRetreat = pop && !empty;
  assign doWrite   = push || popPush;
  assign wrPtr     = doAdvance ? nextPtr : topPtr;

  always_ff @(posedge clk) begin
    if (rst) begin
      topPtr <= PTR_LAST;
      cnt    <= '0;
    end else if (doAdvance) begin
      topPtr <= nextPtr;
      if (cnt != CNT_FULL) cnt <= cnt + CNT_W'(1);
    end else if (doRetreat) begin
      topPtr <= prevPtr;
      cnt    <= cnt - CNT_W'(1);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) entry[i] <= '0;
      else if (doWrite && (wrPtr == PTR_W'(i))) entry[i] <= pushVal;
    end
  end

  assign predValid  = !empty;
  assign predTarget = empty ? '0 : entry[topPtr];

  AST_RAS_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL); // R11
  AST_PUSH_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    push |=> predValid && (predTarget == $past(pushVal))); // R9
  AST_LAST_POP_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (pop && (cnt == CNT_W'(1))) |=> !predValid); // R10
  AST_SWAP_DEPTH: assert property (@(posedge clk) disable iff (rst)
    (popPush && !empty) |=> (cnt == $past(cnt))); // R12
  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> !predValid); // R13

endmodule

// File: rtl/jalr_unit.sv
module jalr_unit
  import jalr_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int RAS_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instValid,
  input  logic [31:0]     instWord,
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] rs1Val,
  output logic            redirectValid,
  output logic [XLEN-1:0] redirectTarget,
  output logic            rfWrEn,
  output logic [4:0]      rfWrAddr,
  output logic [XLEN-1:0] rfWrData,
  output logic            misalignExc,
  output logic            rasPush,
  output logic            rasPop,
  output logic            rasPopPush,
  output logic [XLEN-1:0] predTarget,
  output logic            predValid
);

  logic [6:0]           opcode;
  logic [2:0]           funct3;
  logic [REG_IDX_W-1:0] rdIdx, rs1Idx;
  logic                 immZero, targetBit1;
  logic [XLEN-1:0]      target, linkVal;
  ctrlStrobe_t          strobe;

  jalr_datapath #(.XLEN(XLEN)) u_dp (
    .instWord  (instWord),
    .pcIn      (pcIn),
    .rs1Val    (rs1Val),
    .opcode    (opcode),
    .funct3    (funct3),
    .rdIdx     (rdIdx),
    .rs1Idx    (rs1Idx),
    .immZero   (immZero),
    .targetBit1(targetBit1),
    .target    (target),
    .linkVal   (linkVal)
  );

  jalr_ctrl u_ctrl (
    .instValid (instValid),
    .opcode    (opcode),
    .funct3    (funct3),
    .rdIdx     (rdIdx),
    .rs1Idx    (rs1Idx),
    .immZero   (immZero),
    .targetBit1(targetBit1),
    .strobe    (strobe)
  );

  jalr_ras #(.XLEN(XLEN), .DEPTH(RAS_DEPTH)) u_ras (
    .clk       (clk),
    .rst       (rst),
    .push      (strobe.push),
    .pop       (strobe.pop),
    .popPush   (strobe.popPush),
    .pushVal   (linkVal),
    .predTarget(predTarget),
    .predValid (predValid)
  );

  assign redirectValid  = strobe.redirect;
  assign redirectTarget = target;
  assign rfWrEn         = strobe.linkWr;
  assign rfWrAddr       = rdIdx;
  assign rfWrData       = linkVal;
  assign misalignExc    = strobe.misalign;
  assign rasPush        = strobe.push;
  assign rasPop         = strobe.pop;
  assign rasPopPush     = strobe.popPush;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !strobe.hit |-> !redirectValid && !rfWrEn && !misalignExc); // R1
  AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (rst)
    redirectValid |-> !redirectTarget[0]); // R3
  AST_NO_X0_LINK: assert property (@(posedge clk) disable iff (rst)
    rfWrEn |-> (rfWrAddr != '0)); // R5
  AST_MISALIGN_SILENT: assert property (@(posedge clk) disable iff (rst)
    misalignExc |-> !redirectValid && !rfWrEn && !rasPush && !rasPop && !rasPopPush); // R6
  AST_HINT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rasPush, rasPop, rasPopPush})); // R7
  AST_RET_POPS: assert property (@(posedge clk) disable iff (rst)
    strobe.isReturn |-> rasPop && !rfWrEn); // R8

endmodule

// File: tb/jalr_unit_tb.sv
module jalr_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic [31:0] pcIn = '0;
  logic [31:0] rs1Val = '0;
  logic        redirectValid, rfWrEn, misalignExc, rasPush, rasPop, rasPopPush, predValid;
  logic [31:0] redirectTarget, rfWrData, predTarget;
  logic [4:0]  rfWrAddr;

  int checks = 0;
  int failures = 0;
  logic [31:0] model[$];

  always #4 clk = ~clk;

  jalr_unit u_dut (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .pcIn(pcIn), .rs1Val(rs1Val), .redirectValid(redirectValid),
    .redirectTarget(redirectTarget), .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr),
    .rfWrData(rfWrData), .misalignExc(misalignExc), .rasPush(rasPush),
    .rasPop(rasPop), .rasPopPush(rasPopPush), .predTarget(predTarget),
    .predValid(predValid)
  );

  function automatic logic [31:0] mkInst(input logic [4:0] rd, input logic [4:0] rs1,
                                         input logic [11:0] imm,
                                         input logic [6:0] opc = 7'h67,
                                         input logic [2:0] f3 = 3'b000);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic bit isLink(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One instruction cycle: drive at negedge, check, update the stack model
  task automatic step(input logic [31:0] iw, input logic [31:0] pc,
                      input logic [31:0] r1, input bit v = 1'b1);
    logic [4:0]  rd, rs;
    logic [31:0] immX, tgt, link, predExp;
    bit hit, mis, ok, ePush, ePop, eSwap, eWr, isRet;
    string pTag;
    @(negedge clk);
    instValid = v; instWord = iw; pcIn = pc; rs1Val = r1;
    #1;
    rd    = iw[11:7];
    rs    = iw[19:15];
    immX  = {{20{iw[31]}}, iw[31:20]};
    tgt   = (r1 + immX) & 32'hFFFF_FFFE;
    link  = pc + 32'd4;
    hit   = v && (iw[6:0] == 7'h67) && (iw[14:12] == 3'b000);
    mis   = hit && tgt[1];
    ok    = hit && !mis;
    eWr   = ok && (rd != 5'd0);
    ePush = ok && isLink(rd) && (!isLink(rs) || rd == rs);
    ePop  = ok && isLink(rs) && !isLink(rd);
    eSwap = ok && isLink(rd) && isLink(rs) && rd != rs;
    isRet = ok && rd == 0 && rs == 5'd1 && iw[31:20] == 12'h0;

    chk(redirectValid == ok, hit ? "R2" : "R1", "redirectValid", 32'(redirectValid), 32'(ok));
    chk(misalignExc == mis, mis ? "R6" : "R1", "misalignExc", 32'(misalignExc), 32'(mis));
    chk(rfWrEn == eWr, (rd == 0) ? "R5" : "R4", "rfWrEn", 32'(rfWrEn), 32'(eWr));
    chk({rasPush, rasPop, rasPopPush} == {ePush, ePop, eSwap}, isRet ? "R8" : (hit ? "R7" : "R1"),
        "hints", 32'({rasPush, rasPop, rasPopPush}), 32'({ePush, ePop, eSwap}));
    if (ok) begin
      chk(redirectTarget == tgt, "R2", "redirectTarget", redirectTarget, tgt);
      chk(redirectTarget[0] == 1'b0, "R3", "target bit0", 32'(redirectTarget[0]), 32'd0);
    end
    if (hit) begin
      chk(tgt[1] == misalignExc, "R6", "bit1 vs exc", 32'(misalignExc), 32'(tgt[1]));
    end
    if (eWr) begin
      chk(rfWrAddr == rd, "R4", "rfWrAddr", 32'(rfWrAddr), 32'(rd));
      chk(rfWrData == link, "R4", "rfWrData", rfWrData, link);
    end
    predExp = (model.size() != 0) ? model[$] : 32'h0;
    pTag = (model.size() != 0) ? "R9" : "R10";
    chk(predValid == (model.size() != 0), pTag, "predValid", 32'(predValid), 32'(model.size() != 0));
    chk(predTarget == predExp, pTag, "predTarget", predTarget, predExp);

    if (!rst) begin
      if (ePush) begin
        model.push_back(link);
        if (model.size() > 8) void'(model.pop_front()); // R11 overwrite oldest
      end else if (ePop) begin
        if (model.size() != 0) void'(model.pop_back());
      end else if (eSwap) begin                          // R12
        if (model.size() != 0) void'(model.pop_back());
        model.push_back(link);
      end
    end
  endtask

  task automatic doReset(input int cyc);
    @(negedge clk);
    rst = 1'b1; instValid = 1'b0;
    repeat (cyc) @(negedge clk);
    rst = 1'b0;
    model.delete();
    #1;
    chk(predValid == 1'b0, "R13", "predValid after reset", 32'(predValid), 32'd0);
    chk(predTarget == 32'h0, "R13", "predTarget after reset", predTarget, 32'h0);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [4:0] pickRd, pickRs;
    process::self().srandom(32'd1234);
    doReset(3);

    // R1: wrong opcode, wrong funct3, invalid strobe
    step(mkInst(5'd1, 5'd2, 12'h010, 7'h6F), 32'h100, 32'h2000);
    step(mkInst(5'd1, 5'd2, 12'h010, 7'h67, 3'b001), 32'h104, 32'h2000);
    step(mkInst(5'd1, 5'd2, 12'h010), 32'h108, 32'h2000, 1'b0);
    // R2: wraparound and negative immediate
    step(mkInst(5'd2, 5'd3, 12'h020), 32'h200, 32'hFFFF_FFF0);
    step(mkInst(5'd2, 5'd3, 12'hFFC), 32'h204, 32'h0000_1000);
    // R3: odd sum cleared
    step(mkInst(5'd6, 5'd7, 12'h000), 32'h208, 32'h0000_0101);
    // R5: rd=x0 plain indirect jump
    step(mkInst(5'd0, 5'd7, 12'h004), 32'h20C, 32'h0000_4000);
    // R6: misaligned target, rd=x1 would push
    step(mkInst(5'd1, 5'd7, 12'h000), 32'h210, 32'h0000_0102);
    // R9 / R11: nine pushes overflow the stack
    for (int i = 0; i < 9; i++)
      step(mkInst(5'd1, 5'd9, 12'h000), 32'h1000 + 32'(i * 16), 32'h8000);
    // R8 / R10 / R11: ten returns, last two on an empty stack
    for (int i = 0; i < 10; i++)
      step(mkInst(5'd0, 5'd1, 12'h000), 32'h3000, 32'h0000_5000);
    // R12: pop-then-push on empty, then on a non-empty stack
    step(mkInst(5'd1, 5'd5, 12'h000), 32'h4000, 32'h6000);
    step(mkInst(5'd5, 5'd2, 12'h000), 32'h4010, 32'h6000);
    step(mkInst(5'd1, 5'd5, 12'h000), 32'h4020, 32'h6000);
    step(mkInst(5'd5, 5'd5, 12'h000), 32'h4030, 32'h6000);
    step(mkInst(5'd0, 5'd0, 12'h000), 32'h4040, 32'h6000);
    // R13: reset in the middle empties a loaded stack
    doReset(1);

    for (int n = 0; n < 3000; n++) begin
      logic [4:0] pool [4];
      pool[0] = 5'd0; pool[1] = 5'd1; pool[2] = 5'd5; pool[3] = 5'($urandom_range(2, 31));
      pickRd = ($urandom_range(0, 7) == 0) ? 5'($urandom) : pool[$urandom_range(0, 3)];
      pickRs = ($urandom_range(0, 7) == 0) ? 5'($urandom) : pool[$urandom_range(0, 3)];
      step(mkInst(pickRd, pickRs,
                  ($urandom_range(0, 3) == 0) ? 12'h000 : 12'($urandom),
                  ($urandom_range(0, 9) == 0) ? 7'($urandom) : 7'h67,
                  ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'b000),
           {$urandom, 2'b00} , $urandom, $urandom_range(0, 15) != 0);
      if (n == 1500) doReset(2);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule